// File: doc/BRIEF.md
# Holdover Controller for a Two-Reference Frequency Synthesizer Loop

This controller sits between a tracking loop and the frequency synthesizer that loop steers. It watches two reference inputs and chooses which one the loop follows. When the loop must stop trusting its references, the controller puts it into holdover. In holdover the synthesizer receives a frozen frequency tuning word instead of the live word from the loop filter. The frozen word is captured on the cycle holdover is entered. A control bit picks its source: the averaged word from an external averager, or the last live word seen while the loop was tracking cleanly.

The block runs in one of two modes. In manual mode a holdover pin alone decides holdover, and reference faults have no effect. In automatic mode a fault on the active reference moves the loop to the other reference, or into holdover if no other reference is usable. A reference is usable when its validation flag is set and it shows no loss or out-of-limit fault. Leaving holdover automatically needs the revert enable bit. Every change of reference passes through a one-cycle switching state.

Top module: `holdover_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `in_holdover` = 0, `switching` = 0, `active_ref` = 0 (reference 0) and `ftw_out` = 0.
- R2: While tracking (not in holdover), `ftw_out` equals the `loop_ftw` value presented on the previous clock.
- R3: In manual mode (`auto_mode` = 0), `hold_pin` = 1 sets `in_holdover` on the next clock. When `hold_pin` returns to 0, `in_holdover` clears on the next clock, `active_ref` is unchanged and `ftw_out` follows `loop_ftw` again.
- R4: In manual mode, the fault and validation inputs (`ref_lor`, `ref_ool`, `ref_valid`) never cause holdover or a change of reference.
- R5: In automatic mode, a fault on the active reference (`ref_lor` or `ref_ool` bit of that reference high) while the other reference is usable raises `switching` for exactly one clock. `active_ref` takes the other reference's index on that clock. During switching `ftw_out` carries `loop_ftw`.
- R6: In automatic mode, a fault on the active reference while the other reference is not usable sets `in_holdover` on the next clock.
- R7: With `use_avg` = 1, the held word is the `avg_ftw` presented on the cycle holdover is entered. `ftw_out` stays constant for as long as holdover lasts, whatever `avg_ftw` and `loop_ftw` do.
- R8: With `use_avg` = 0, the held word is the `loop_ftw` of the last cycle on which the loop was tracking with no holdover request or fault on its active reference.
- R9: In automatic mode, holdover with `revert_en` = 1 and at least one usable reference leaves through one switching clock. The target is reference 0 if it is usable, otherwise reference 1.
- R10: In automatic mode with `revert_en` = 0, holdover persists even when both references are usable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_lor | input | 2 | Per-reference loss-of-reference flag |
| ref_ool | input | 2 | Per-reference out-of-limit flag |
| ref_valid | input | 2 | Per-reference validation-timer-expired flag |
| auto_mode | input | 1 | 1 = automatic holdover control, 0 = manual (pin) |
| hold_pin | input | 1 | Manual holdover request |
| revert_en | input | 1 | Allow automatic exit from holdover to a recovered reference |
| use_avg | input | 1 | 1 = hold the averaged word, 0 = hold the last clean live word |
| loop_ftw | input | FTW_W | Live tuning word from the loop filter |
| avg_ftw | input | FTW_W | Averaged tuning word |
| in_holdover | output | 1 | Holdover status |
| switching | output | 1 | High for the one clock of a reference change |
| active_ref | output | 1 | Index of the selected reference |
| ftw_out | output | FTW_W | Tuning word applied to the synthesizer |

## Verification
The main function is tried with a manual pin pulse while faults are forced on both references, which separates pin-driven holdover from fault-driven holdover. An automatic fault on one reference with the other usable, then with none usable, separates a switch from holdover entry. Holdover is entered once with each held-word source while the live and averaged words keep changing, which shows whether the word was captured at entry or is still tracking. Recovery is tried with revert disabled, then with both references usable at once, and later with only reference 1 usable, which checks the revert gate and the preference order.

// File: rtl/holdover_pkg.sv
package holdover_pkg;
  localparam int NREF = 2;

  typedef enum logic [1:0] {
    ST_LOCK0  = 2'd0,
    ST_LOCK1  = 2'd1,
    ST_HOLD   = 2'd2,
    ST_SWITCH = 2'd3
  } hold_state_t;
endpackage

// File: rtl/ref_qualify.sv
module ref_qualify #(
  parameter int N = 2
) (
  input  logic [N-1:0] lor,
  input  logic [N-1:0] ool,
  input  logic [N-1:0] valid,
  output logic [N-1:0] fault,
  output logic [N-1:0] usable
);
  for (genvar i = 0; i < N; i++) begin : g_ref
    assign fault[i]  = lor[i] | ool[i];
    assign usable[i] = valid[i] & ~lor[i] & ~ool[i];
  end
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import holdover_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              auto_mode,
  input  logic              hold_pin,
  input  logic              revert_en,
  input  logic [NREF-1:0]   fault,
  input  logic [NREF-1:0]   usable,
  output hold_state_t       state,
  output logic              nxt_hold,
  output logic              enter_hold,
  output logic              track_en,
  output logic              active_ref
);
  hold_state_t nxt;
  logic        tgt;
  logic        locked;
  logic        hold_req;

  assign locked   = (state == ST_LOCK0) || (state == ST_LOCK1);
  assign hold_req = auto_mode ? fault[active_ref] : hold_pin;

  always_comb begin
    nxt = state;
    tgt = active_ref;
    case (state)
      ST_LOCK0, ST_LOCK1: begin
        if (hold_req) begin
          if (auto_mode && usable[~active_ref]) begin
            nxt = ST_SWITCH;
            tgt = ~active_ref;
          end else begin
            nxt = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (!auto_mode) begin
          if (!hold_pin) nxt = active_ref ? ST_LOCK1 : ST_LOCK0;
        end else if (revert_en && (|usable)) begin
          nxt = ST_SWITCH;
          tgt = usable[0] ? 1'b0 : 1'b1;
        end
      end
      ST_SWITCH: nxt = active_ref ? ST_LOCK1 : ST_LOCK0;
      default:   nxt = ST_LOCK0;
    endcase
  end

  assign nxt_hold   = (nxt == ST_HOLD);
  assign enter_hold = nxt_hold && (state != ST_HOLD);
  assign track_en   = locked && !hold_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_LOCK0;
      active_ref <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt == ST_SWITCH) active_ref <= tgt;
    end
  end

  // R5
  switch_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SWITCH) |=> (state != ST_SWITCH));

  // R5
  switch_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SWITCH) |=> (state == (active_ref ? ST_LOCK1 : ST_LOCK0)));

  // R4
  manual_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (!auto_mode && !hold_pin && locked) |=> ((state != ST_HOLD) && $stable(active_ref)));

  // R10
  no_revert_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_HOLD) && auto_mode && !revert_en) |=> (state == ST_HOLD));
endmodule

// File: rtl/ftw_hold.sv
module ftw_hold #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_hold,
  input  logic         nxt_hold,
  input  logic         enter_hold,
  input  logic         track_en,
  input  logic         use_avg,
  input  logic [W-1:0] loop_ftw,
  input  logic [W-1:0] avg_ftw,
  output logic [W-1:0] ftw_out
);
  logic [W-1:0] last_good;
  logic [W-1:0] held;
  logic [W-1:0] held_nxt;

  assign held_nxt = enter_hold ? (use_avg ? avg_ftw : last_good) : held;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_good <= '0;
      held      <= '0;
      ftw_out   <= '0;
    end else begin
      if (track_en) last_good <= loop_ftw;
      held    <= held_nxt;
      ftw_out <= nxt_hold ? held_nxt : loop_ftw;
    end
  end

  // R7
  held_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (in_hold && nxt_hold) |=> $stable(ftw_out));

  // R2
  track_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!nxt_hold) |=> (ftw_out == $past(loop_ftw)));
endmodule

// File: rtl/holdover_ctrl.sv
module holdover_ctrl
  import holdover_pkg::*;
#(
  parameter int FTW_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ref_lor,
  input  logic [1:0]       ref_ool,
  input  logic [1:0]       ref_valid,
  input  logic             auto_mode,
  input  logic             hold_pin,
  input  logic             revert_en,
  input  logic             use_avg,
  input  logic [FTW_W-1:0] loop_ftw,
  input  logic [FTW_W-1:0] avg_ftw,
  output logic             in_holdover,
  output logic             switching,
  output logic             active_ref,
  output logic [FTW_W-1:0] ftw_out
);
  logic [NREF-1:0] fault;
  logic [NREF-1:0] usable;
  hold_state_t     state;
  logic            nxt_hold;
  logic            enter_hold;
  logic            track_en;

  ref_qualify #(.N(NREF)) u_qual (
    .lor    (ref_lor),
    .ool    (ref_ool),
    .valid  (ref_valid),
    .fault  (fault),
    .usable (usable)
  );

  hold_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .auto_mode  (auto_mode),
    .hold_pin   (hold_pin),
    .revert_en  (revert_en),
    .fault      (fault),
    .usable     (usable),
    .state      (state),
    .nxt_hold   (nxt_hold),
    .enter_hold (enter_hold),
    .track_en   (track_en),
    .active_ref (active_ref)
  );

  ftw_hold #(.W(FTW_W)) u_ftw (
    .clk        (clk),
    .rst        (rst),
    .in_hold    (in_holdover),
    .nxt_hold   (nxt_hold),
    .enter_hold (enter_hold),
    .track_en   (track_en),
    .use_avg    (use_avg),
    .loop_ftw   (loop_ftw),
    .avg_ftw    (avg_ftw),
    .ftw_out    (ftw_out)
  );

  assign in_holdover = (state == ST_HOLD);
  assign switching   = (state == ST_SWITCH);

  // R9
  exit_via_switch_chk: assert property (@(posedge clk) disable iff (rst)
    (in_holdover && auto_mode) |=> (in_holdover || switching));
endmodule

// File: tb/holdover_ctrl_tb.sv
`timescale 1ns/1ps
module holdover_ctrl_tb_top;
  localparam int W = 48;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   ref_lor = '0, ref_ool = '0, ref_valid = 2'b11;
  logic         auto_mode = 1'b0, hold_pin = 1'b0, revert_en = 1'b0, use_avg = 1'b0;
  logic [W-1:0] loop_ftw = '0, avg_ftw = '0;
  logic         in_holdover, switching, active_ref;
  logic [W-1:0] ftw_out;

  typedef struct {
    logic         hold;
    logic         sw;
    logic         aref;
    logic [W-1:0] ftw;
    string        req;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  holdover_ctrl #(.FTW_W(W)) dut_i (
    .clk(clk), .rst(rst), .ref_lor(ref_lor), .ref_ool(ref_ool), .ref_valid(ref_valid),
    .auto_mode(auto_mode), .hold_pin(hold_pin), .revert_en(revert_en), .use_avg(use_avg),
    .loop_ftw(loop_ftw), .avg_ftw(avg_ftw),
    .in_holdover(in_holdover), .switching(switching), .active_ref(active_ref), .ftw_out(ftw_out)
  );

  task automatic compare(input exp_t e);
    n_chk++;
    if (in_holdover !== e.hold || switching !== e.sw || active_ref !== e.aref || ftw_out !== e.ftw) begin
      n_fail++;
      $display("FAIL %s: got hold=%0b sw=%0b ref=%0b ftw=%0d, expected hold=%0b sw=%0b ref=%0b ftw=%0d",
               e.req, in_holdover, switching, active_ref, ftw_out, e.hold, e.sw, e.aref, e.ftw);
    end
  endtask

  // driver: inputs already set at a negedge; push the expectation for the next edge
  task automatic tick(input logic h, input logic s, input logic r, input logic [W-1:0] f, input string req);
    exp_t e;
    e.hold = h; e.sw = s; e.aref = r; e.ftw = f; e.req = req;
    q.push_back(e);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    r.hold = 0; r.sw = 0; r.aref = 0; r.ftw = '0; r.req = "R1 reset";
    compare(r);
    rst = 1'b0;
    // manual mode tracking
    loop_ftw = 100;                              tick(0, 0, 0, 100, "R1/R2 first cycle");
    loop_ftw = 101;                              tick(0, 0, 0, 101, "R2 track");
    ref_lor = 2'b11; ref_ool = 2'b11; ref_valid = 2'b00; loop_ftw = 102;
                                                 tick(0, 0, 0, 102, "R4 faults ignored manual");
    ref_lor = 0; ref_ool = 0; ref_valid = 2'b11; hold_pin = 1; loop_ftw = 103;
                                                 tick(1, 0, 0, 102, "R3/R8 pin enters holdover");
    loop_ftw = 104; avg_ftw = 77;                tick(1, 0, 0, 102, "R7 held stable");
    hold_pin = 0; loop_ftw = 105;                tick(0, 0, 0, 105, "R3 pin release");
    // automatic mode
    auto_mode = 1; revert_en = 1; loop_ftw = 106; tick(0, 0, 0, 106, "R2 auto track");
    ref_lor = 2'b01; ref_valid = 2'b10; loop_ftw = 107;
                                                 tick(0, 1, 1, 107, "R5 switch to ref1");
    loop_ftw = 108;                              tick(0, 0, 1, 108, "R5 locked ref1");
    use_avg = 1; avg_ftw = 500; ref_ool = 2'b10; ref_valid = 2'b00; loop_ftw = 109;
                                                 tick(1, 0, 1, 500, "R6/R7 enter holdover avg");
    avg_ftw = 600; loop_ftw = 110;               tick(1, 0, 1, 500, "R7 held stable avg");
    revert_en = 0; ref_lor = 0; ref_ool = 0; ref_valid = 2'b11;
                                                 tick(1, 0, 1, 500, "R10 no revert");
    revert_en = 1; loop_ftw = 111;               tick(0, 1, 0, 111, "R9 tie prefers ref0");
    loop_ftw = 112;                              tick(0, 0, 0, 112, "R9 locked ref0");
    use_avg = 0; loop_ftw = 113;                 tick(0, 0, 0, 113, "R2 track");
    ref_lor = 2'b01; ref_valid = 2'b00; loop_ftw = 114;
                                                 tick(1, 0, 0, 113, "R8 last clean word");
    loop_ftw = 115;                              tick(1, 0, 0, 113, "R7 held stable last");
    ref_valid = 2'b10; loop_ftw = 116;           tick(0, 1, 1, 116, "R9 recover to ref1");
    loop_ftw = 117;                              tick(0, 0, 1, 117, "R9 locked ref1");
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule